// File: doc/BRIEF.md
# Indexed Palette Register Extension

This block is a small colour register file that hangs off a CPU I/O bus. Software reaches it through two ports. It first writes a code to the select port. That code picks either one of 64 palette entries or the mode-control register. It then writes or reads the data port, and that access goes to whichever target the code picked.

The video pipeline has its own lookup path. It presents a 6-bit palette index and gets back an 8-bit colour (green in bits 7:5, red in bits 4:2, blue in bits 1:0) in the same cycle, with no clock in between. A palette write is seen by the very next pixel that is looked up, so a program timed to the raster can recolour the picture partway through a line. Entry 8 is the one the pixel path presents for both border colour 0 and paper colour 0, so rewriting it mid-line recolours both areas at once.

While the extension is switched off, the lookup path ignores the stored entries. It drives a fixed 8-colour mapping taken from the low three index bits.

Top module: `pal_ext_regs`

## Requirements
- R1: After reset the extension is off, the select register holds 0x00 and every palette entry holds 0x00.
- R2: A write with `io_addr` = 0xBF3B loads `io_wdata` into the select register. A write or read with `io_addr` = 0xFF3B goes to the target that the select register names.
- R3: With select bits 7:6 = 00, bits 5:0 name a palette entry. A data-port write stores the 8-bit colour in that entry, and a data-port read returns it.
- R4: A select value of 64 (bits 7:6 = 01) names the mode register. A data write sets the extension-enable flag to `io_wdata[0]`, and a data read returns 0x01 when the flag is on and 0x00 when it is off.
- R5: With the extension on, `pix_colour` equals the entry named by `pix_index`. It follows a change of `pix_index` combinationally, with no clock edge.
- R6: A palette write is visible on `pix_colour` from the first cycle after the write edge, at any point in the frame.
- R7: With the extension off, `pix_colour` is {3{idx[2]}, 3{idx[1]}, 2{idx[0]}}, where idx is `pix_index`. Switching the extension off and on again leaves the stored entries unchanged.
- R8: Writes to any other address change nothing. A data-port access while select bits 7:6 are 10 or 11 stores nothing, and a read returns 0x00.
- R9: `io_rdata` is 0x00 whenever `io_rd` is low, and also when `io_rd` is high but the address is not the data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| pix_index | input | 6 | Palette index from the pixel path |
| pix_colour | output | 8 | Looked-up colour, G3:R3:B2 |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle: the select and mode registers load on their own port writes, they hold still when no write reaches them, and a palette write shows up one cycle later at a matching lookup index. They also check the fixed colour mapping whenever the extension is off and the quiet read bus when no read is made. Other behaviours can only be shown by the bench's scenarios. These are the contents of entries that are not being looked up, the ignored writes to reserved groups, the entries surviving a mode toggle, and the combinational response to an index change.

// File: rtl/pal_ext_pkg.sv
// Shared constants, the select-group encoding and the fallback colour map.
// Assumes an 8-bit colour word laid out as green 7:5, red 4:2, blue 1:0.
package pal_ext_pkg;

    localparam int COL_W = 8;

    // Group field held in the top two select bits
    typedef enum logic [1:0] {
        GRP_PALETTE = 2'b00,
        GRP_MODE    = 2'b01,
        GRP_SPARE_A = 2'b10,
        GRP_SPARE_B = 2'b11
    } sel_group_e;

    // Fixed 8-colour map used while the extension is off
    function automatic logic [COL_W-1:0] base_colour(input logic [2:0] grb);
        return {{3{grb[2]}}, {3{grb[1]}}, {2{grb[0]}}};
    endfunction

endpackage

// File: rtl/pal_bus_decode.sv
// Turns raw I/O bus strobes into per-port enables.
// Assumes a full 16-bit address compare, one strobe per access.
module pal_bus_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'hBF3B,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'hFF3B
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              sel_we,
    output logic              dat_we,
    output logic              dat_re
);

    // Match the address against the two port numbers
    always_comb begin
        sel_we = io_wr && (io_addr == SEL_PORT);
        dat_we = io_wr && (io_addr == DAT_PORT);
        dat_re = io_rd && (io_addr == DAT_PORT);
    end

endmodule

// File: rtl/pal_select_mode.sv
// Holds the select register and the extension-enable flag, and routes
// data-port writes to the palette store.
// Assumes IDX_W <= DATA_W - 2 so the index field sits below the group field.
module pal_select_mode
    import pal_ext_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sel_q,
    output logic              mode_en,
    output sel_group_e        grp,
    output logic [IDX_W-1:0]  entry_idx,
    output logic              entry_we
);

    localparam int GRP_LSB = DATA_W - 2;

    // Select register: loaded by every select-port write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= wdata;
    end

    // Split the select value into group and entry index
    always_comb begin
        grp       = sel_group_e'(sel_q[DATA_W-1:GRP_LSB]);
        entry_idx = sel_q[IDX_W-1:0];
        entry_we  = dat_we && (grp == GRP_PALETTE);
    end

    // Enable flag: bit 0 of a data write while the mode group is selected
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_en <= 1'b0;
        else if (dat_we && (grp == GRP_MODE))
            mode_en <= wdata[0];
    end

endmodule

// File: rtl/pal_store.sv
// Palette storage: one write port, two combinational read ports (bus and
// pixel), so a write is seen by lookups from the next cycle on.
// Assumes ENTRIES = 2**IDX_W.
module pal_store #(
    parameter int IDX_W = 6,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [COL_W-1:0] wdata,
    input  logic [IDX_W-1:0] bus_addr,
    output logic [COL_W-1:0] bus_data,
    input  logic [IDX_W-1:0] pix_addr,
    output logic [COL_W-1:0] pix_data
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [COL_W-1:0] entry_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // One colour register, cleared by reset, loaded when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[e] <= '0;
            else if (we && (waddr == IDX_W'(e)))
                entry_q[e] <= wdata;
        end
    end

    // Two independent read ports
    always_comb begin
        bus_data = entry_q[bus_addr];
        pix_data = entry_q[pix_addr];
    end

endmodule

// File: rtl/pal_ext_regs.sv
// Top of the palette extension: bus decode, select/mode control, entry
// storage, and the colour lookup with its fallback map.
// Assumes single-cycle bus strobes and a combinational pixel lookup.
module pal_ext_regs
    import pal_ext_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              IDX_W    = 6,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'hBF3B,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'hFF3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [COL_W-1:0]  io_wdata,
    output logic [COL_W-1:0]  io_rdata,
    input  logic [IDX_W-1:0]  pix_index,
    output logic [COL_W-1:0]  pix_colour
);

    logic             sel_we, dat_we, dat_re;
    logic [COL_W-1:0] sel_q;
    logic             mode_en;
    sel_group_e       grp;
    logic [IDX_W-1:0] entry_idx;
    logic             entry_we;
    logic [COL_W-1:0] bus_entry, pix_entry;

    pal_bus_decode #(
        .ADDR_W  (ADDR_W),
        .SEL_PORT(SEL_PORT),
        .DAT_PORT(DAT_PORT)
    ) u_decode (
        .io_addr(io_addr),
        .io_wr  (io_wr),
        .io_rd  (io_rd),
        .sel_we (sel_we),
        .dat_we (dat_we),
        .dat_re (dat_re)
    );

    pal_select_mode #(
        .DATA_W(COL_W),
        .IDX_W (IDX_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (sel_we),
        .dat_we   (dat_we),
        .wdata    (io_wdata),
        .sel_q    (sel_q),
        .mode_en  (mode_en),
        .grp      (grp),
        .entry_idx(entry_idx),
        .entry_we (entry_we)
    );

    pal_store #(
        .IDX_W(IDX_W),
        .COL_W(COL_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (entry_we),
        .waddr   (entry_idx),
        .wdata   (io_wdata),
        .bus_addr(entry_idx),
        .bus_data(bus_entry),
        .pix_addr(pix_index),
        .pix_data(pix_entry)
    );

    // Pixel path: stored entry when enabled, fixed map otherwise
    always_comb begin
        pix_colour = mode_en ? pix_entry : base_colour(pix_index[2:0]);
    end

    // Read path: only data-port reads return anything
    always_comb begin
        io_rdata = '0;
        if (dat_re) begin
            case (grp)
                GRP_PALETTE: io_rdata = bus_entry;
                GRP_MODE:    io_rdata = {{(COL_W-1){1'b0}}, mode_en};
                default:     io_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pal_ext_regs_chk.sv
// Cycle-level properties of the palette extension, bound to the top.
// Assumes the same port numbers and widths as the bound instance.
module pal_ext_regs_chk #(
    parameter int              ADDR_W   = 16,
    parameter int              IDX_W    = 6,
    parameter int              COL_W    = 8,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'hBF3B,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'hFF3B
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [COL_W-1:0]  io_wdata,
    input logic [COL_W-1:0]  io_rdata,
    input logic [IDX_W-1:0]  pix_index,
    input logic [COL_W-1:0]  pix_colour,
    input logic [COL_W-1:0]  sel_q,
    input logic              mode_en
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mode_en && sel_q == '0));

    // R2
    select_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == SEL_PORT) |=> (sel_q == $past(io_wdata)));

    // R4
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DAT_PORT && sel_q[COL_W-1:COL_W-2] == 2'b01)
        |=> (mode_en == $past(io_wdata[0])));

    // R6
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DAT_PORT && sel_q[COL_W-1:COL_W-2] == 2'b00 &&
         mode_en && pix_index == sel_q[IDX_W-1:0])
        |=> ((pix_index != $past(pix_index)) || (pix_colour == $past(io_wdata))));

    // R7
    fallback_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (pix_colour[7:5] == {3{pix_index[2]}} &&
                      pix_colour[4:2] == {3{pix_index[1]}} &&
                      pix_colour[1:0] == {2{pix_index[0]}}));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && (io_addr == SEL_PORT || io_addr == DAT_PORT))
        |=> ($stable(sel_q) && $stable(mode_en)));

    // R9
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));

endmodule

bind pal_ext_regs pal_ext_regs_chk #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .COL_W   (pal_ext_pkg::COL_W),
    .SEL_PORT(SEL_PORT),
    .DAT_PORT(DAT_PORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .pix_index (pix_index),
    .pix_colour(pix_colour),
    .sel_q     (sel_q),
    .mode_en   (mode_en)
);

// File: tb/pal_ext_regs_test.sv
module pal_ext_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SELP = 16'hBF3B;
    localparam logic [15:0] DATP = 16'hFF3B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [5:0]  pix_index = '0;
    logic [7:0]  pix_colour;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_ext_regs uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .pix_index(pix_index), .pix_colour(pix_colour)
    );

    function automatic logic [7:0] fixed_map(input logic [5:0] i);
        return {{3{i[2]}}, {3{i[1]}}, {2{i[0]}}};
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0; io_addr = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        bus_read(DATP, d);
        check(d == 8'h00, "R1 entry0 after reset", d, 8'h00);
        for (int i = 0; i < 8; i++) begin
            pix_index = 6'(i); #1;
            check(pix_colour == fixed_map(6'(i)), "R1 mode off after reset", pix_colour, fixed_map(6'(i)));
        end
        bus_write(SELP, 8'd64);
        bus_read(DATP, d);
        check(d == 8'h00, "R1 mode reg after reset", d, 8'h00);
        bus_write(SELP, 8'd37);
        bus_read(DATP, d);
        check(d == 8'h00, "R1 entry37 after reset", d, 8'h00);
    endtask

    task automatic t_entries;
        logic [7:0] d;
        for (int i = 0; i < 64; i++) begin
            model[i] = 8'((i * 37 + 11) ^ (i << 2));
            bus_write(SELP, 8'(i));
            bus_write(DATP, model[i]);
        end
        for (int i = 0; i < 64; i += 9) begin
            bus_write(SELP, 8'(i));
            bus_read(DATP, d);
            check(d == model[i], "R3 entry readback", d, model[i]);
        end
        bus_write(SELP, 8'd63);
        bus_read(DATP, d);
        check(d == model[63], "R2 select picks entry 63", d, model[63]);
    endtask

    task automatic t_mode_on;
        logic [7:0] d;
        bus_write(SELP, 8'd64);
        bus_write(DATP, 8'h01);
        bus_read(DATP, d);
        check(d == 8'h01, "R4 mode readback on", d, 8'h01);
        for (int i = 0; i < 64; i += 5) begin
            pix_index = 6'(i); #1;
            check(pix_colour == model[i], "R5 lookup", pix_colour, model[i]);
        end
        pix_index = 6'd8; #1;
        check(pix_colour == model[8], "R5 lookup entry 8", pix_colour, model[8]);
        pix_index = 6'd9; #1;
        check(pix_colour == model[9], "R5 index change without clock", pix_colour, model[9]);
    endtask

    task automatic t_midline;
        bus_write(SELP, 8'd8);
        pix_index = 6'd8;
        bus_write(DATP, 8'h5A);
        model[8] = 8'h5A;
        check(pix_colour == 8'h5A, "R6 first write visible", pix_colour, 8'h5A);
        bus_write(DATP, 8'hA5);
        model[8] = 8'hA5;
        check(pix_colour == 8'hA5, "R6 second write visible", pix_colour, 8'hA5);
    endtask

    task automatic t_ignored;
        logic [7:0] d;
        bus_write(16'h3B3B, 8'h11);
        bus_write(16'hBF3C, 8'h22);
        bus_write(16'hFF3A, 8'h33);
        bus_read(DATP, d);
        check(d == 8'hA5, "R8 stray addresses ignored", d, 8'hA5);
        bus_write(SELP, 8'h80);
        bus_write(DATP, 8'h77);
        bus_read(DATP, d);
        check(d == 8'h00, "R8 reserved group reads zero", d, 8'h00);
        bus_write(SELP, 8'hC0);
        bus_write(DATP, 8'h66);
        bus_write(SELP, 8'h00);
        bus_read(DATP, d);
        check(d == model[0], "R8 entry0 untouched", d, model[0]);
        pix_index = 6'd0; #1;
        check(pix_colour == model[0], "R8 mode still on", pix_colour, model[0]);
    endtask

    task automatic t_mode_off;
        logic [7:0] d;
        bus_write(SELP, 8'd64);
        bus_write(DATP, 8'h00);
        bus_read(DATP, d);
        check(d == 8'h00, "R4 mode readback off", d, 8'h00);
        for (int i = 0; i < 64; i += 7) begin
            pix_index = 6'(i); #1;
            check(pix_colour == fixed_map(6'(i)), "R7 fixed map", pix_colour, fixed_map(6'(i)));
        end
        bus_write(DATP, 8'hFF);
        for (int i = 3; i < 64; i += 10) begin
            pix_index = 6'(i); #1;
            check(pix_colour == model[i], "R7 entries kept", pix_colour, model[i]);
        end
    endtask

    task automatic t_read_idle;
        @(negedge clk);
        io_addr = DATP; io_rd = 1'b0; #1;
        check(io_rdata == 8'h00, "R9 no strobe", io_rdata, 8'h00);
        io_addr = SELP; io_rd = 1'b1; #1;
        check(io_rdata == 8'h00, "R9 select port read", io_rdata, 8'h00);
        io_rd = 1'b0; io_addr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_entries;
        t_mode_on;
        t_midline;
        t_ignored;
        t_mode_off;
        t_read_idle;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=00 expected=01");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule